// File: doc/BRIEF.md
# Bidirectional Digital Ramp Generator

This block produces a 32-bit ramp word that climbs or descends between a programmable floor and ceiling. The rising and falling segments each have their own increment and their own step interval. A step-interval timer counts down, and each time it expires the ramp moves by one increment in the direction that an external input selects. A hold input freezes the ramp and its timer where they are. A clear input snaps the ramp back to the floor.

Settings are written through a small parallel port into staging registers. They become live together on a single-cycle commit strobe. A destination select decides how many of the upper ramp bits reach the output, so the same word can drive a frequency, a phase or an amplitude control.

Top module: `ramp_gen`

## Requirements
- R1: After reset, `ramp_out` is 0, every live and staged setting is 0, and the interval timer is 0.
- R2: A write with `wr_en` high stores `wr_data` into a staging register selected by `wr_addr`. The addresses are: 0 floor, 1 ceiling, 2 rising increment, 3 falling increment, 4 rising interval (`wr_data[15:0]`), 5 falling interval (`wr_data[15:0]`). Writes to addresses 6 and 7 are ignored. Staged values do not take effect until `commit` is high for one cycle, which copies all of them to the live settings.
- R3: `clear` loads the ramp with the live floor and reloads the timer with the current direction's interval. It takes priority over `hold`.
- R4: While `dir_up` is high and nothing holds the ramp, the timer counts down once per cycle. In the cycle it reads 0, the ramp rises by the rising increment and the timer reloads with the rising interval. After a clear, the first step therefore lands interval+1 cycles later, and each later step follows interval+1 cycles after the one before.
- R5: While `dir_up` is low, steps use the falling increment and the falling interval, which are independent of the rising settings.
- R6: A rising step that would pass the ceiling, including a sum that carries out of 32 bits, leaves the ramp at the ceiling.
- R7: A falling step that would pass the floor, including a difference that borrows below zero, leaves the ramp at the floor.
- R8: While `hold` is high and `clear` is low, neither the ramp nor the timer changes. Writes and commits are still accepted.
- R9: `dest_sel` picks the output form. A value of 0 or 3 gives all 32 bits (frequency). A value of 1 gives bits 31:16 with the low 16 bits zero (phase). A value of 2 gives bits 31:18 with the low 18 bits zero (amplitude).
- R10: `at_limit` is high when `dir_up` is high and the ramp equals the ceiling, or when `dir_up` is low and the ramp equals the floor. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Staging register write enable |
| wr_addr | input | 3 | Staging register select |
| wr_data | input | 32 | Staging register write data |
| commit | input | 1 | Copy all staged settings to the live settings |
| dir_up | input | 1 | 1 selects rising, 0 selects falling |
| hold | input | 1 | Freeze the ramp and its timer |
| clear | input | 1 | Load the ramp with the floor |
| dest_sel | input | 2 | Output form: frequency, phase or amplitude |
| ramp_out | output | 32 | Ramp word, truncated to its destination |
| at_limit | output | 1 | Ramp sits at the limit it is heading toward |

## Verification
A corrupted timer shows up as a step that lands in the wrong cycle. The bench catches this within one interval, because every value check is placed on the exact edge where a step is or is not due. A wrong accumulator or a missed saturation gives a wrong `ramp_out` at the very next step. Saturation at either limit is also visible at once on `at_limit`. A staging error surfaces on the first clear after a commit, when the ramp loads a floor other than the one committed.

// File: rtl/ramp_gen.sv
module ramp_gen #(
  parameter int ACC_W   = 32,
  parameter int TMR_W   = 16,
  parameter int PHASE_W = 16,
  parameter int AMPL_W  = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [ACC_W-1:0] wr_data,
  input  logic             commit,
  input  logic             dir_up,
  input  logic             hold,
  input  logic             clear,
  input  logic [1:0]       dest_sel,
  output logic [ACC_W-1:0] ramp_out,
  output logic             at_limit
);

  localparam logic [ACC_W-1:0] PHASE_MASK = {{PHASE_W{1'b1}}, {(ACC_W-PHASE_W){1'b0}}};
  localparam logic [ACC_W-1:0] AMPL_MASK  = {{AMPL_W{1'b1}}, {(ACC_W-AMPL_W){1'b0}}};

  logic [ACC_W-1:0] st_floor, st_ceil, st_rinc, st_finc;
  logic [TMR_W-1:0] st_rint, st_fint;
  logic [ACC_W-1:0] lv_floor, lv_ceil, lv_rinc, lv_finc;
  logic [TMR_W-1:0] lv_rint, lv_fint;

  logic [ACC_W-1:0] acc, rise_nx, fall_nx;
  logic [TMR_W-1:0] tmr;
  logic [ACC_W:0]   sum, diff;

  wire [TMR_W-1:0] cur_int = dir_up ? lv_rint : lv_fint;
  wire             tick    = (tmr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_floor <= '0; st_ceil <= '0; st_rinc <= '0;
      st_finc  <= '0; st_rint <= '0; st_fint <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        3'd0: st_floor <= wr_data;
        3'd1: st_ceil  <= wr_data;
        3'd2: st_rinc  <= wr_data;
        3'd3: st_finc  <= wr_data;
        3'd4: st_rint  <= wr_data[TMR_W-1:0];
        3'd5: st_fint  <= wr_data[TMR_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lv_floor <= '0; lv_ceil <= '0; lv_rinc <= '0;
      lv_finc  <= '0; lv_rint <= '0; lv_fint <= '0;
    end else if (commit) begin
      lv_floor <= st_floor; lv_ceil <= st_ceil; lv_rinc <= st_rinc;
      lv_finc  <= st_finc;  lv_rint <= st_rint; lv_fint <= st_fint;
    end
  end

  assign sum  = {1'b0, acc} + {1'b0, lv_rinc};
  assign diff = {1'b0, acc} - {1'b0, lv_finc};

  always_comb begin
    if (acc >= lv_ceil || sum[ACC_W] || sum[ACC_W-1:0] > lv_ceil)
      rise_nx = lv_ceil;
    else
      rise_nx = sum[ACC_W-1:0];
    if (acc <= lv_floor || diff[ACC_W] || diff[ACC_W-1:0] < lv_floor)
      fall_nx = lv_floor;
    else
      fall_nx = diff[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      tmr <= '0;
    end else if (clear) begin
      acc <= lv_floor;
      tmr <= cur_int;
    end else if (!hold) begin
      if (tick) begin
        acc <= dir_up ? rise_nx : fall_nx;
        tmr <= cur_int;
      end else begin
        tmr <= tmr - 1'b1;
      end
    end
  end

  always_comb begin
    case (dest_sel)
      2'd1:    ramp_out = acc & PHASE_MASK;
      2'd2:    ramp_out = acc & AMPL_MASK;
      default: ramp_out = acc;
    endcase
  end

  assign at_limit = dir_up ? (acc == lv_ceil) : (acc == lv_floor);

  p_hold_acc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !clear) |=> $stable(acc));
  p_hold_tmr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !clear) |=> $stable(tmr));
  p_clear_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (acc == $past(lv_floor)));
  p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !clear && tmr != '0) |=> $stable(acc));
  p_ceil_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !clear && tick && dir_up) |=> (acc <= $past(lv_ceil)));
  p_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !clear && tick && !dir_up) |=> (acc >= $past(lv_floor)));

endmodule

// File: tb/ramp_gen_bench.sv
module ramp_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        commit = 1'b0;
  logic        dir_up = 1'b0;
  logic        hold = 1'b0;
  logic        clear = 1'b0;
  logic [1:0]  dest_sel = '0;
  logic [31:0] ramp_out;
  logic        at_limit;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  ramp_gen u_ramp_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .commit(commit), .dir_up(dir_up), .hold(hold),
    .clear(clear), .dest_sel(dest_sel), .ramp_out(ramp_out), .at_limit(at_limit)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_commit();
    commit = 1'b1; @(negedge clk); commit = 1'b0;
  endtask

  task automatic do_clear();
    clear = 1'b1; @(negedge clk); clear = 1'b0; #1;
  endtask

  task automatic t_reset();
    chk("R1 ramp after reset", ramp_out, 32'd0);
    chk("R1 at_limit after reset", {31'd0, at_limit}, 32'd1);
  endtask

  task automatic t_rise();
    hold = 1'b1;
    wr(3'd0, 32'd100); wr(3'd1, 32'd1000); wr(3'd2, 32'd50);
    wr(3'd3, 32'd30);  wr(3'd4, 32'd3);    wr(3'd5, 32'd1);
    do_commit();
    dir_up = 1'b1;
    do_clear();
    hold = 1'b0;
    chk("R3 clear loads floor", ramp_out, 32'd100);
    tick(3); chk("R4 no step before interval", ramp_out, 32'd100);
    tick(1); chk("R4 first rising step", ramp_out, 32'd150);
    tick(4); chk("R4 second rising step", ramp_out, 32'd200);
  endtask

  task automatic t_sat_and_fall();
    hold = 1'b1;
    wr(3'd2, 32'd600); do_commit();
    do_clear();
    hold = 1'b0;
    tick(4); chk("R4 step 600", ramp_out, 32'd700);
    tick(4); chk("R6 saturate at ceiling", ramp_out, 32'd1000);
    chk("R10 at_limit rising", {31'd0, at_limit}, 32'd1);
    tick(4); chk("R6 stays at ceiling", ramp_out, 32'd1000);
    dir_up = 1'b0; #1;
    chk("R10 at_limit low when falling away", {31'd0, at_limit}, 32'd0);
    tick(3); chk("R5 no falling step yet", ramp_out, 32'd1000);
    tick(1); chk("R5 first falling step", ramp_out, 32'd970);
    tick(2); chk("R5 falling interval 1", ramp_out, 32'd940);
  endtask

  task automatic t_hold_floor();
    hold = 1'b1;
    tick(5); chk("R8 hold freezes ramp", ramp_out, 32'd940);
    wr(3'd3, 32'd500); do_commit();
    hold = 1'b0;
    tick(1); chk("R8 timer resumes where frozen", ramp_out, 32'd940);
    tick(1); chk("R5 step after hold", ramp_out, 32'd440);
    tick(2); chk("R7 saturate at floor with borrow", ramp_out, 32'd100);
    chk("R10 at_limit falling", {31'd0, at_limit}, 32'd1);
  endtask

  task automatic t_carry();
    hold = 1'b1;
    wr(3'd0, 32'hFFFF_FF00); wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd2, 32'h0000_0200); wr(3'd4, 32'd0);
    do_commit();
    dir_up = 1'b1;
    do_clear();
    hold = 1'b0;
    chk("R3 clear to new floor", ramp_out, 32'hFFFF_FF00);
    tick(1); chk("R6 carry saturates", ramp_out, 32'hFFFF_FFFF);
    tick(1); chk("R6 carry stays", ramp_out, 32'hFFFF_FFFF);
  endtask

  task automatic t_stage_dest();
    hold = 1'b1;
    wr(3'd0, 32'hABCD_1234);
    do_clear();
    chk("R2 staged floor not live", ramp_out, 32'hFFFF_FF00);
    do_commit();
    do_clear();
    chk("R3 clear overrides hold", ramp_out, 32'hABCD_1234);
    wr(3'd7, 32'h0000_0001); wr(3'd6, 32'h0000_0002); do_commit();
    tick(3);
    chk("R8 held ramp unchanged", ramp_out, 32'hABCD_1234);
    do_clear();
    chk("R2 addresses 6 and 7 ignored", ramp_out, 32'hABCD_1234);
    dest_sel = 2'd1; #1; chk("R9 phase form", ramp_out, 32'hABCD_0000);
    dest_sel = 2'd2; #1; chk("R9 amplitude form", ramp_out, 32'hABCC_0000);
    dest_sel = 2'd3; #1; chk("R9 code 3 full word", ramp_out, 32'hABCD_1234);
    dest_sel = 2'd0; #1; chk("R9 frequency form", ramp_out, 32'hABCD_1234);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_rise();
    t_sat_and_fall();
    t_hold_floor();
    t_carry();
    t_stage_dest();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule